// File: doc/BRIEF.md
# SHA-1 Four-Round Compression Unit

This unit advances a SHA-1 working state by four consecutive rounds. The caller presents a 128-bit state operand holding the A, B, C and D words, a 128-bit operand holding four message words, and a control value. The low two bits of the control value pick one boolean mixing function and one additive constant, and both hold for all four rounds. The fifth working variable E starts at zero. The caller folds any prior E into the first message word before issuing the operation.

A one-cycle start pulse captures the operands while the unit is idle. The unit then runs `RND_PER_CLK` rounds per clock, with a default of one. When the last round completes it raises a one-cycle done pulse, and the packed A to D result is valid on the output in that same cycle. The result stays on the output until the next accepted start. Message expansion, the final feed-forward addition and the E pre-fold are left to surrounding logic.

Top module: `sha1_quad_round`

## Requirements
- R1: Only bits [1:0] of `ctrl_i` are used, and the upper bits have no effect on the result. Selector value 0 uses constant 0x5A827999, value 1 uses 0x6ED9EBA1, value 2 uses 0x8F1BBCDC and value 3 uses 0xCA62C1D6.
- R2: Selector 0 uses the choose function (B&C)^(~B&D). Selectors 1 and 3 use parity B^C^D. Selector 2 uses majority (B&C)^(B&D)^(C&D).
- R3: The starting A, B, C and D are taken from `state_i` bits [127:96], [95:64], [63:32] and [31:0] in that order, and the starting E is zero.
- R4: Round n (0..3) uses the message word in `msg_i` bits [32*(3-n)+31 : 32*(3-n)], so the first round consumes bits [127:96].
- R5: Each round computes new A = f(B,C,D) + rotl(A,5) + W + E + K modulo 2^32, new B = A, new C = rotl(B,30), new D = C and new E = D.
- R6: The result on `state_o` packs A in bits [31:0], B in [63:32], C in [95:64] and D in [127:96].
- R7: A start seen at a clock edge while idle is accepted, and `busy_o` rises after that edge. With the default of one round per clock, `done_o` is high for exactly one cycle, four edges after the accepting edge, and `busy_o` is low in that cycle.
- R8: A start pulse that arrives while busy is ignored. It neither alters the running result nor restarts the latency count.
- R9: A synchronous reset clears `busy_o`, `done_o` and `state_o` to zero.
- R10: While idle and with no start, `state_o` holds the last result unchanged, even when the operand inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start request pulse |
| ctrl_i | input | CTRL_W | Control value; bits [1:0] select function and constant |
| state_i | input | 128 | Packed starting A, B, C, D |
| msg_i | input | 128 | Four packed message words |
| busy_o | output | 1 | Rounds in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| state_o | output | 128 | Packed resulting A, B, C, D |

## Verification
The checker watches the handshake on every cycle. It confirms that an accepted start sets busy, that busy ends only through done, and that done lands on the expected cycle and lasts a single cycle. It also confirms that reset clears the outputs and that the result holds steady while idle. The arithmetic can only be shown by the bench's scenarios: the mixing function and constant per selector, the lane order of state and message words, and the rotations and modular sums. The same holds for the proofs that ignored inputs have no effect, namely the upper control bits and a start issued mid-run. The bench compares these against its own round model.

// File: rtl/sha1q_pkg.sv
package sha1q_pkg;
   localparam int WORD_W = 32;
   localparam int LANES  = 4;
   localparam int DATA_W = WORD_W * LANES;

   typedef logic [WORD_W-1:0] word_t;

   typedef struct packed {
      word_t a;
      word_t b;
      word_t c;
      word_t d;
      word_t e;
   } wstate_t;

   function automatic word_t rotl(input word_t v, input int unsigned s);
      return (v << s) | (v >> (WORD_W - s));
   endfunction

   function automatic word_t round_const(input logic [1:0] sel);
      case (sel)
         2'd0:    return 32'h5A827999;
         2'd1:    return 32'h6ED9EBA1;
         2'd2:    return 32'h8F1BBCDC;
         default: return 32'hCA62C1D6;
      endcase
   endfunction
endpackage

// File: rtl/sha1q_boolfn.sv
module sha1q_boolfn
   import sha1q_pkg::*;
(
   input  logic [1:0] sel,
   input  word_t      b,
   input  word_t      c,
   input  word_t      d,
   output word_t      f
);
   word_t f_choose, f_parity, f_major;

   assign f_choose = (b & c) ^ (~b & d);
   assign f_parity = b ^ c ^ d;
   assign f_major  = (b & c) ^ (b & d) ^ (c & d);

   always_comb begin
      case (sel)
         2'd0:    f = f_choose;
         2'd2:    f = f_major;
         default: f = f_parity;
      endcase
   end
endmodule

// File: rtl/sha1q_round.sv
module sha1q_round
   import sha1q_pkg::*;
(
   input  logic [1:0] sel,
   input  word_t      w,
   input  wstate_t    cur,
   output wstate_t    nxt
);
   word_t mix;

   sha1q_boolfn u_fn (
      .sel (sel),
      .b   (cur.b),
      .c   (cur.c),
      .d   (cur.d),
      .f   (mix)
   );

   always_comb begin
      nxt.a = mix + rotl(cur.a, 5) + w + cur.e + round_const(sel);
      nxt.b = cur.a;
      nxt.c = rotl(cur.b, 30);
      nxt.d = cur.c;
      nxt.e = cur.d;
   end
endmodule

// File: rtl/sha1q_seq.sv
module sha1q_seq #(
   parameter int STEPS = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic load,
   output logic busy,
   output logic done
);
   localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;

   logic [CW-1:0] step_q;

   assign load = start && !busy;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy   <= 1'b0;
         done   <= 1'b0;
         step_q <= '0;
      end else begin
         done <= 1'b0;
         if (load) begin
            busy   <= 1'b1;
            step_q <= '0;
         end else if (busy) begin
            if (step_q == CW'(STEPS - 1)) begin
               busy   <= 1'b0;
               done   <= 1'b1;
               step_q <= '0;
            end else begin
               step_q <= step_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/sha1_quad_round.sv
module sha1_quad_round
   import sha1q_pkg::*;
#(
   parameter int CTRL_W      = 8,
   parameter int RND_PER_CLK = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_i,
   input  logic [CTRL_W-1:0] ctrl_i,
   input  logic [127:0]      state_i,
   input  logic [127:0]      msg_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [127:0]      state_o
);
   localparam int NUM_ROUNDS = LANES;
   localparam int STEPS      = NUM_ROUNDS / RND_PER_CLK;

   generate
      if (CTRL_W < 2) begin : g_bad_ctrl
         $error("CTRL_W must be at least 2");
      end
      if (RND_PER_CLK < 1 || (NUM_ROUNDS % RND_PER_CLK) != 0) begin : g_bad_rpc
         $error("RND_PER_CLK must divide the round count");
      end
      if (DATA_W != 128) begin : g_bad_width
         $error("packed operand width must be 128");
      end
      if (CTRL_W > 2) begin : g_ctrl_hi
         logic unused_ctrl_hi;
         assign unused_ctrl_hi = ^ctrl_i[CTRL_W-1:2];
      end
   endgenerate

   logic              load;
   wstate_t           st_q;
   logic [DATA_W-1:0] msg_q;
   logic [1:0]        sel_q;
   wstate_t           chain [RND_PER_CLK+1];

   sha1q_seq #(.STEPS(STEPS)) u_seq (
      .clk   (clk),
      .rst   (rst),
      .start (start_i),
      .load  (load),
      .busy  (busy_o),
      .done  (done_o)
   );

   assign chain[0] = st_q;

   generate
      for (genvar k = 0; k < RND_PER_CLK; k++) begin : g_rnd
         sha1q_round u_rnd (
            .sel (sel_q),
            .w   (msg_q[DATA_W-1-k*WORD_W -: WORD_W]),
            .cur (chain[k]),
            .nxt (chain[k+1])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q  <= '0;
         msg_q <= '0;
         sel_q <= '0;
      end else if (load) begin
         st_q.a <= state_i[127:96];
         st_q.b <= state_i[95:64];
         st_q.c <= state_i[63:32];
         st_q.d <= state_i[31:0];
         st_q.e <= '0;
         msg_q  <= msg_i;
         sel_q  <= ctrl_i[1:0];
      end else if (busy_o) begin
         st_q  <= chain[RND_PER_CLK];
         msg_q <= msg_q << (WORD_W * RND_PER_CLK);
      end
   end

   assign state_o = {st_q.d, st_q.c, st_q.b, st_q.a};
endmodule

// File: rtl/sha1q_quad_chk.sv
module sha1q_quad_chk #(
   parameter int STEPS = 4
) (
   input logic         clk,
   input logic         rst,
   input logic         start_i,
   input logic         busy_o,
   input logic         done_o,
   input logic [127:0] state_o
);
   logic [7:0] trk_cyc;

   always_ff @(posedge clk) begin
      if (rst)                        trk_cyc <= '0;
      else if (start_i && !busy_o)    trk_cyc <= '0;
      else if (busy_o)                trk_cyc <= trk_cyc + 8'd1;
   end

   AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
      start_i && !busy_o |=> busy_o); // R7
   AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
      done_o |-> trk_cyc == 8'(STEPS)); // R7
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      done_o && !start_i |=> !done_o); // R7
   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
      done_o |-> !busy_o); // R7
   AST_BUSY_ENDS_IN_DONE: assert property (@(posedge clk) disable iff (rst)
      busy_o |=> busy_o || done_o); // R8
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !busy_o && !start_i |=> $stable(state_o)); // R10
   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> !busy_o && !done_o && state_o == '0); // R9
endmodule

bind sha1_quad_round sha1q_quad_chk #(.STEPS(NUM_ROUNDS / RND_PER_CLK)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .start_i (start_i),
   .busy_o  (busy_o),
   .done_o  (done_o),
   .state_o (state_o)
);

// File: tb/tb_sha1_quad_round.sv
`timescale 1ns/1ps
module tb_sha1_quad_round;
   logic         clk = 1'b0;
   logic         rst;
   logic         start_i;
   logic [7:0]   ctrl_i;
   logic [127:0] state_i;
   logic [127:0] msg_i;
   logic         busy_o;
   logic         done_o;
   logic [127:0] state_o;

   int total = 0;
   int bad   = 0;

   always #2.5 clk = ~clk;

   sha1_quad_round dut (
      .clk(clk), .rst(rst), .start_i(start_i), .ctrl_i(ctrl_i),
      .state_i(state_i), .msg_i(msg_i), .busy_o(busy_o),
      .done_o(done_o), .state_o(state_o)
   );

   localparam int NV = 8;
   // {state, msg, ctrl}
   localparam logic [263:0] VEC [NV] = '{
      {128'h0, 128'h0, 8'h00},
      {128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF, 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF, 8'h01},
      {128'h67452301_EFCDAB89_98BADCFE_10325476, 128'h61626380_00000000_00000000_00000018, 8'h00},
      {128'h01234567_89ABCDEF_FEDCBA98_76543210, 128'h11111111_22222222_33333333_44444444, 8'h01},
      {128'hDEADBEEF_CAFEBABE_0BADF00D_8BADF00D, 128'h80000000_00000001_7FFFFFFF_FFFFFFFE, 8'h02},
      {128'hA5A5A5A5_5A5A5A5A_F0F0F0F0_0F0F0F0F, 128'h00000001_00000002_00000004_00000008, 8'h03},
      {128'h00000000_00000000_00000000_80000000, 128'hFFFFFFFF_00000000_00000000_00000000, 8'h02},
      {128'h13579BDF_2468ACE0_FEDCBA98_01020304, 128'hCAFEF00D_12345678_9ABCDEF0_0F1E2D3C, 8'h03}
   };

   function automatic logic [31:0] r5(input logic [31:0] v);
      return {v[26:0], v[31:27]};
   endfunction
   function automatic logic [31:0] r30(input logic [31:0] v);
      return {v[1:0], v[31:2]};
   endfunction

   function automatic logic [127:0] model(input logic [127:0] s, input logic [127:0] m,
                                          input logic [7:0] ctl);
      logic [31:0] a, b, c, d, e, f, k, w, t;
      a = s[127:96]; b = s[95:64]; c = s[63:32]; d = s[31:0]; e = 32'h0;   // R3
      case (ctl[1:0])                                                     // R1
         2'd0: k = 32'h5A827999;
         2'd1: k = 32'h6ED9EBA1;
         2'd2: k = 32'h8F1BBCDC;
         default: k = 32'hCA62C1D6;
      endcase
      for (int n = 0; n < 4; n++) begin
         w = m[32*(3-n) +: 32];                                           // R4
         case (ctl[1:0])                                                  // R2
            2'd0: f = (b & c) | (~b & d);
            2'd2: f = (b & c) | (b & d) | (c & d);
            default: f = b ^ c ^ d;
         endcase
         t = f + r5(a) + w + e + k;                                       // R5
         e = d; d = c; c = r30(b); b = a; a = t;
      end
      return {d, c, b, a};                                                // R6
   endfunction

   task automatic check(input bit ok, input string req, input logic [127:0] act,
                        input logic [127:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_op(input logic [127:0] s, input logic [127:0] m, input logic [7:0] c,
                         input bit inject, output logic [127:0] res, output int lat);
      @(negedge clk);
      state_i = s; msg_i = m; ctrl_i = c; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      lat = 0;
      while (!done_o && lat < 20) begin
         @(negedge clk);
         lat++;
         if (inject && lat == 1) begin
            start_i = 1'b1; state_i = ~s; msg_i = ~m; ctrl_i = c ^ 8'h01;
         end else begin
            start_i = 1'b0;
         end
      end
      start_i = 1'b0;
      res = state_o;
   endtask

   initial begin
      for (int cyc = 0; cyc < 100000; cyc++) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog R7 actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [127:0] res, res2, exp;
      int lat;
      rst = 1'b1; start_i = 1'b0; ctrl_i = '0; state_i = '1; msg_i = '1;
      repeat (3) @(negedge clk);
      check(busy_o == 1'b0, "R9 busy", {127'b0, busy_o}, 128'h0);
      check(done_o == 1'b0, "R9 done", {127'b0, done_o}, 128'h0);
      check(state_o == '0, "R9 state", state_o, 128'h0);
      rst = 1'b0;

      // vector table: R1..R7
      for (int i = 0; i < NV; i++) begin
         run_op(VEC[i][263:136], VEC[i][135:8], VEC[i][7:0], 1'b0, res, lat);
         exp = model(VEC[i][263:136], VEC[i][135:8], VEC[i][7:0]);
         check(lat == 4, "R7 latency", 128'(lat), 128'd4);
         check(res == exp, "R5 result vector", res, exp);
      end

      // R7: done lasts one cycle, busy low after
      @(negedge clk);
      check(done_o == 1'b0 && busy_o == 1'b0, "R7 single done", {126'b0, done_o, busy_o}, 128'h0);

      // R10: hold while idle with changing inputs
      state_i = 128'h1234; msg_i = 128'h5678; ctrl_i = 8'h02;
      repeat (3) @(negedge clk);
      check(state_o == res, "R10 hold", state_o, res);

      // R1: upper control bits ignored
      run_op(VEC[3][263:136], VEC[3][135:8], 8'hFD, 1'b0, res, lat);
      exp = model(VEC[3][263:136], VEC[3][135:8], 8'h01);
      check(res == exp, "R1 upper ctrl ignored", res, exp);
      run_op(VEC[4][263:136], VEC[4][135:8], 8'h7E, 1'b0, res2, lat);
      exp = model(VEC[4][263:136], VEC[4][135:8], 8'h02);
      check(res2 == exp, "R1 upper ctrl ignored sel2", res2, exp);

      // R8: start while busy ignored
      run_op(VEC[2][263:136], VEC[2][135:8], 8'h00, 1'b1, res, lat);
      exp = model(VEC[2][263:136], VEC[2][135:8], 8'h00);
      check(lat == 4, "R8 latency unchanged", 128'(lat), 128'd4);
      check(res == exp, "R8 result unchanged", res, exp);
      @(negedge clk);
      check(busy_o == 1'b0, "R8 no restart", {127'b0, busy_o}, 128'h0);

      // R2/R3/R4: symmetric operands that differ only per lane position
      run_op(128'h00000001_00000000_00000000_00000000, 128'h0, 8'h00, 1'b0, res, lat);
      exp = model(128'h00000001_00000000_00000000_00000000, 128'h0, 8'h00);
      check(res == exp, "R3 lane order A", res, exp);
      run_op(128'h0, 128'h00000000_00000000_00000000_00000001, 8'h03, 1'b0, res, lat);
      exp = model(128'h0, 128'h00000000_00000000_00000000_00000001, 8'h03);
      check(res == exp, "R4 last message lane", res, exp);
      run_op(128'h0, 128'h0, 8'h02, 1'b0, res, lat);
      exp = model(128'h0, 128'h0, 8'h02);
      check(res == exp, "R2 majority zero state", res, exp);

      // R9: reset mid-operation
      @(negedge clk);
      state_i = VEC[5][263:136]; msg_i = VEC[5][135:8]; ctrl_i = 8'h03; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check(busy_o == 1'b0 && done_o == 1'b0 && state_o == '0, "R9 reset mid-run",
            state_o, 128'h0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule